// File: doc/BRIEF.md
# Banked Seven-Segment Display Controller

This block sits on a processor bus and drives an eight-digit, time-multiplexed seven-segment LED display. Each bus write is a one-cycle strobe with an eight-bit data byte. A select input, usually taken from the low address bit, sends the byte either to the control register or to the display memory. The control register sets the digit address, the bank, the run/shutdown state, decoded or raw display, and the hexadecimal or Code-B character set. Bit 7 of the control word, called "load", arms the block for data writes that follow.

In decoded mode each digit stores a four-bit value in one of two banks, A and B. There is one decimal-point bit per digit, and both banks share it. In raw mode each digit stores an eight-bit segment pattern directly, and the raw store has no banks. A scanner steps through the digits in a fixed order. It drives one digit-enable line at a time, together with that digit's segment pattern.

Top module: `segdisp_ctrl`

## Requirements
- R1: After reset the control register reads zero, so the block is in shutdown, and `dig_en` and `seg_out` are all zero. All stored digits are zero.
- R2: A control write (`sel_ctrl`=1) with bit 7 = 0 changes only the control register and stores no digit. Any data write (`sel_ctrl`=0) made while the block is not armed is ignored.
- R3: A control write with bit 7 = 1 and bit 5 = 1 arms a single-digit load. The next data write stores data[3:0] into the digit chosen by control bits 2:0, in the bank chosen by control bit 3, and stores data[7] as that digit's decimal point. Data writes after that one are ignored.
- R4: A control write with bit 7 = 1 and bit 5 = 0 arms a sequential raw load. The next eight data writes store full bytes into digits 0 to 7 in that order. A ninth data write is ignored.
- R5: When bit 5 = 1 and bit 6 = 1, digit values 0 to 15 are shown as hexadecimal characters 0 to 9 and A, b, C, d, E, F. The segment bits are a = `seg_out[0]` through g = `seg_out[6]`.
- R6: When bit 5 = 1 and bit 6 = 0, values 0 to 9 are shown as numerals. Values 10 to 15 are shown as dash, E, H, L, P and blank.
- R7: The two banks hold independent values. Control bit 3 (0 = A, 1 = B) selects both the bank that is written and the bank shown on all eight digits.
- R8: Each digit has a single decimal-point bit, driven on `seg_out[7]` in decoded mode, and it is lit whichever bank is shown.
- R9: When control bit 4 = 0 (shutdown), `dig_en` and `seg_out` are zero. Stored digits are kept and reappear when bit 4 returns to 1.
- R10: While running, exactly one `dig_en` bit is high at a time. The enable steps through digits 0 to 7 in ascending order, wrapping from 7 to 0, and holds each digit for SLOT_CYCLES clocks. Raw mode shows the stored byte unchanged on `seg_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| sel_ctrl | input | 1 | 1: write to the control register, 0: write to the display memory |
| wr_data | input | 8 | Write data byte |
| seg_out | output | 8 | Segments a..g on bits 0..6, decimal point on bit 7 |
| dig_en | output | 8 | One-hot active-high digit enable |

## Verification
A wrong internal state reaches the ports within one scan sweep of 8×SLOT_CYCLES clocks. A bad armed state or a bad sequential index puts a byte in the wrong digit position. A bank mix-up makes the wrong character appear on every digit at once. A bad scan counter shows up as two enables high together, a digit skipped, or a wrong dwell time. Every table entry in both character sets is swept. Each store, show and shutdown step is followed by a full sweep that compares all eight digits against a model in the bench.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int NUM_DIGITS = 8;
  localparam int IDX_W      = $clog2(NUM_DIGITS);

  // field order follows control word bit 7 down to bit 0
  typedef struct packed {
    logic             load;
    logic             hex;
    logic             decode;
    logic             run;
    logic             bank;
    logic [IDX_W-1:0] addr;
  } ctrl_t;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_ONE  = 2'd1,
    ARM_SEQ  = 2'd2
  } arm_e;

  // segment order: bit0 = a ... bit6 = g
  function automatic logic [6:0] hex_seg(input logic [3:0] v);
    case (v)
      4'h0: hex_seg = 7'h3F;
      4'h1: hex_seg = 7'h06;
      4'h2: hex_seg = 7'h5B;
      4'h3: hex_seg = 7'h4F;
      4'h4: hex_seg = 7'h66;
      4'h5: hex_seg = 7'h6D;
      4'h6: hex_seg = 7'h7D;
      4'h7: hex_seg = 7'h07;
      4'h8: hex_seg = 7'h7F;
      4'h9: hex_seg = 7'h6F;
      4'hA: hex_seg = 7'h77;
      4'hB: hex_seg = 7'h7C;
      4'hC: hex_seg = 7'h39;
      4'hD: hex_seg = 7'h5E;
      4'hE: hex_seg = 7'h79;
      default: hex_seg = 7'h71;
    endcase
  endfunction

  function automatic logic [6:0] codeb_seg(input logic [3:0] v);
    case (v)
      4'hA: codeb_seg = 7'h40;
      4'hB: codeb_seg = 7'h79;
      4'hC: codeb_seg = 7'h76;
      4'hD: codeb_seg = 7'h38;
      4'hE: codeb_seg = 7'h73;
      4'hF: codeb_seg = 7'h00;
      default: codeb_seg = hex_seg(v);
    endcase
  endfunction
endpackage

// File: rtl/segdisp_ctrlreg.sv
module segdisp_ctrlreg
  import segdisp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             sel_ctrl,
  input  logic [7:0]       wr_data,
  output ctrl_t            ctrl,
  output logic             dec_we,
  output logic             raw_we,
  output logic [IDX_W-1:0] we_addr,
  output logic [7:0]       we_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  arm_e             arm_q;
  logic [IDX_W-1:0] seq_idx_q;
  logic             ctrl_wr;
  logic             data_wr;

  assign ctrl_wr = wr_stb & sel_ctrl;
  assign data_wr = wr_stb & ~sel_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      arm_q     <= ARM_NONE;
      seq_idx_q <= '0;
    end else if (ctrl_wr) begin
      ctrl      <= ctrl_t'(wr_data);
      seq_idx_q <= '0;
      if (wr_data[7]) arm_q <= wr_data[5] ? ARM_ONE : ARM_SEQ;
      else            arm_q <= ARM_NONE;
    end else if (data_wr) begin
      case (arm_q)
        ARM_ONE: arm_q <= ARM_NONE;
        ARM_SEQ: begin
          seq_idx_q <= seq_idx_q + 1'b1;
          if (seq_idx_q == LAST_IDX) arm_q <= ARM_NONE;
        end
        default: arm_q <= ARM_NONE;
      endcase
    end
  end

  assign dec_we  = data_wr & (arm_q == ARM_ONE);
  assign raw_we  = data_wr & (arm_q == ARM_SEQ);
  assign we_addr = (arm_q == ARM_SEQ) ? seq_idx_q : ctrl.addr;
  assign we_data = wr_data;

  assert_ctrlonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[7]) |=> (arm_q == ARM_NONE));
  assert_single_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_we |=> (arm_q == ARM_NONE));
  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_we && seq_idx_q != LAST_IDX) |=> (seq_idx_q == $past(seq_idx_q) + 1'b1));
  assert_seq_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_we && seq_idx_q == LAST_IDX) |=> (arm_q == ARM_NONE));
endmodule

// File: rtl/segdisp_store.sv
module segdisp_store
  import segdisp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_we,
  input  logic             raw_we,
  input  logic             we_bank,
  input  logic [IDX_W-1:0] we_addr,
  input  logic [7:0]       we_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_bank,
  output logic [3:0]       rd_nib,
  output logic             rd_dp,
  output logic [7:0]       rd_raw
);
  logic [NUM_DIGITS-1:0][3:0] bank_a_q;
  logic [NUM_DIGITS-1:0][3:0] bank_b_q;
  logic [NUM_DIGITS-1:0]      dp_q;
  logic [NUM_DIGITS-1:0][7:0] raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_a_q <= '0;
      bank_b_q <= '0;
      dp_q     <= '0;
      raw_q    <= '0;
    end else begin
      if (dec_we) begin
        if (we_bank) bank_b_q[we_addr] <= we_data[3:0];
        else         bank_a_q[we_addr] <= we_data[3:0];
        dp_q[we_addr] <= we_data[7];
      end
      if (raw_we) raw_q[we_addr] <= we_data;
    end
  end

  assign rd_nib = rd_bank ? bank_b_q[rd_idx] : bank_a_q[rd_idx];
  assign rd_dp  = dp_q[rd_idx];
  assign rd_raw = raw_q[rd_idx];

  assert_bank_b_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_we && !we_bank) |=> $stable(bank_b_q));
  assert_bank_a_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_we && we_bank) |=> $stable(bank_a_q));
  assert_raw_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_we |=> $stable(raw_q));
  assert_dec_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_we |=> ($stable(bank_a_q) && $stable(bank_b_q) && $stable(dp_q)));
  assert_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_we && !raw_we) |=> ($stable(bank_a_q) && $stable(bank_b_q) && $stable(raw_q)));
endmodule

// File: rtl/segdisp_scan.sv
module segdisp_scan
  import segdisp_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  decode,
  input  logic                  hex,
  input  logic [3:0]            rd_nib,
  input  logic                  rd_dp,
  input  logic [7:0]            rd_raw,
  output logic [IDX_W-1:0]      scan_idx,
  output logic [7:0]            seg_out,
  output logic [NUM_DIGITS-1:0] dig_en
);
  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_DIGITS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              slot_tick;
  logic [7:0]        pattern;

  assign slot_tick = (slot_q == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      scan_idx <= '0;
    end else if (slot_tick) begin
      slot_q   <= '0;
      scan_idx <= (scan_idx == IDX_LAST) ? '0 : scan_idx + 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  always_comb begin
    if (decode) pattern = {rd_dp, hex ? hex_seg(rd_nib) : codeb_seg(rd_nib)};
    else        pattern = rd_raw;
  end

  assign seg_out = run ? pattern : 8'h00;
  assign dig_en  = run ? (NUM_DIGITS'(1) << scan_idx) : '0;

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(dig_en) == 1));
  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && scan_idx != IDX_LAST) |=> (scan_idx == $past(scan_idx) + 1'b1));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && scan_idx == IDX_LAST) |=> (scan_idx == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(scan_idx));
  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (dig_en == '0 && seg_out == 8'h00));
endmodule

// File: rtl/segdisp_ctrl.sv
module segdisp_ctrl
  import segdisp_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       sel_ctrl,
  input  logic [7:0] wr_data,
  output logic [7:0] seg_out,
  output logic [7:0] dig_en
);
  ctrl_t            ctrl;
  logic             dec_we;
  logic             raw_we;
  logic [IDX_W-1:0] we_addr;
  logic [7:0]       we_data;
  logic [IDX_W-1:0] scan_idx;
  logic [3:0]       rd_nib;
  logic             rd_dp;
  logic [7:0]       rd_raw;

  segdisp_ctrlreg u_ctrlreg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel_ctrl(sel_ctrl),
    .wr_data(wr_data), .ctrl(ctrl), .dec_we(dec_we), .raw_we(raw_we),
    .we_addr(we_addr), .we_data(we_data)
  );

  segdisp_store u_store (
    .clk(clk), .rst_n(rst_n), .dec_we(dec_we), .raw_we(raw_we),
    .we_bank(ctrl.bank), .we_addr(we_addr), .we_data(we_data),
    .rd_idx(scan_idx), .rd_bank(ctrl.bank),
    .rd_nib(rd_nib), .rd_dp(rd_dp), .rd_raw(rd_raw)
  );

  segdisp_scan #(.SLOT_CYCLES(SLOT_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .decode(ctrl.decode),
    .hex(ctrl.hex), .rd_nib(rd_nib), .rd_dp(rd_dp), .rd_raw(rd_raw),
    .scan_idx(scan_idx), .seg_out(seg_out), .dig_en(dig_en)
  );

  assert_reset_blank_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (dig_en == 8'h00 && seg_out == 8'h00));
endmodule

// File: tb/segdisp_ctrl_tb.sv
`timescale 1ns/1ps
module segdisp_ctrl_tb;
  localparam int SLOT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic       sel_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] seg_out;
  logic [7:0] dig_en;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] m_ctrl = 8'h00;
  int         m_arm = 0;
  int         m_seq = 0;
  logic [3:0] m_a [8];
  logic [3:0] m_b [8];
  logic       m_dp [8];
  logic [7:0] m_raw [8];

  always #2.5 clk = ~clk;

  segdisp_ctrl #(.SLOT_CYCLES(SLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel_ctrl(sel_ctrl),
    .wr_data(wr_data), .seg_out(seg_out), .dig_en(dig_en)
  );

  // segment bits a..g = 0..6; built from which segments are lit
  function automatic logic [6:0] segs(input string lit);
    logic [6:0] r = '0;
    for (int k = 0; k < lit.len(); k++) r[lit[k] - "a"] = 1'b1;
    return r;
  endfunction

  function automatic logic [6:0] ref_hex(input int v);
    string s [16] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg", "acdfg",
                      "acdefg", "abc", "abcdefg", "abcdfg", "abcefg",
                      "cdefg", "adef", "bcdeg", "adefg", "aefg"};
    return segs(s[v]);
  endfunction

  function automatic logic [6:0] ref_codeb(input int v);
    string s [6] = '{"g", "adefg", "bcefg", "def", "abefg", ""};
    if (v < 10) return ref_hex(v);
    return (v == 15) ? 7'h00 : segs(s[v - 10]);
  endfunction

  function automatic logic [7:0] exp_seg(input int i);
    int n;
    if (!m_ctrl[4]) return 8'h00;
    if (!m_ctrl[5]) return m_raw[i];
    n = m_ctrl[3] ? int'(m_b[i]) : int'(m_a[i]);
    return {m_dp[i], m_ctrl[6] ? ref_hex(n) : ref_codeb(n)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit ctl, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; sel_ctrl = ctl; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    if (ctl) begin
      m_ctrl = d;
      m_seq  = 0;
      m_arm  = d[7] ? (d[5] ? 1 : 2) : 0;
    end else if (m_arm == 1) begin
      if (m_ctrl[3]) m_b[m_ctrl[2:0]] = d[3:0];
      else           m_a[m_ctrl[2:0]] = d[3:0];
      m_dp[m_ctrl[2:0]] = d[7];
      m_arm = 0;
    end else if (m_arm == 2) begin
      m_raw[m_seq] = d;
      m_seq++;
      if (m_seq == 8) m_arm = 0;
    end
  endtask

  // watch two full sweeps; compare every digit with the model
  task automatic sweep(input string req);
    logic [7:0] got [8];
    bit seen [8];
    int prev = -1;
    int run_len = 0;
    int first = 1;
    bit bad_scan = 0;
    logic [7:0] bad_val = '0;
    for (int i = 0; i < 8; i++) seen[i] = 0;
    for (int c = 0; c < 16 * SLOT; c++) begin
      @(negedge clk);
      if (!m_ctrl[4]) begin
        if (dig_en != 0 || seg_out != 0) begin bad_scan = 1; bad_val = dig_en | seg_out; end
      end else if ($countones(dig_en) != 1) begin
        bad_scan = 1; bad_val = dig_en;
      end else begin
        int idx = 0;
        for (int k = 0; k < 8; k++) if (dig_en[k]) idx = k;
        if (prev >= 0 && idx != prev) begin
          if (idx != (prev + 1) % 8) begin bad_scan = 1; bad_val = dig_en; end
          if (!first && run_len != SLOT) begin bad_scan = 1; bad_val = 8'(run_len); end
          first = 0;
          run_len = 0;
        end
        run_len++;
        prev = idx;
        got[idx] = seg_out;
        seen[idx] = 1;
      end
    end
    check(!bad_scan, {req, " scan order/blanking R10"}, 32'(bad_val), 32'h0);
    if (m_ctrl[4]) begin
      for (int i = 0; i < 8; i++)
        check(seen[i] && got[i] == exp_seg(i), req, {24'h0, got[i]}, {24'h0, exp_seg(i)});
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R10 got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_a[i] = '0; m_b[i] = '0; m_dp[i] = 1'b0; m_raw[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is shutdown with blank outputs
    sweep("R1");
    // R1 / R10: running raw view of an all-zero store
    wr(1'b1, 8'h10);
    sweep("R1");

    // R4: sequential raw load, ninth write ignored
    wr(1'b1, 8'h90);
    for (int i = 0; i < 8; i++) wr(1'b0, 8'((i * 37 + 11) & 255));
    wr(1'b0, 8'hA5);
    sweep("R4");

    // R2: control-only write, then stray data writes
    wr(1'b1, 8'h17);
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h00);
    sweep("R2");

    // R5 / R6: every value in both character sets, bank A
    for (int pass = 0; pass < 2; pass++) begin
      for (int d = 0; d < 8; d++) begin
        wr(1'b1, 8'hF0 | 8'(d));
        wr(1'b0, {d[0], 3'b000, 4'(pass * 8 + d)});
      end
      sweep("R5");
      wr(1'b1, 8'h30);
      sweep("R6");
    end

    // R7: bank B filled separately, both banks shown
    for (int d = 0; d < 8; d++) begin
      wr(1'b1, 8'hF8 | 8'(d));
      wr(1'b0, 8'(15 - d));
    end
    wr(1'b1, 8'h78);
    sweep("R7");
    wr(1'b1, 8'h70);
    sweep("R7");

    // R8: decimal point set via bank A shows with bank B
    wr(1'b1, 8'hF5);
    wr(1'b0, 8'h83);
    wr(1'b1, 8'h78);
    sweep("R8");

    // R9: shutdown blanks, contents survive
    wr(1'b1, 8'h68);
    sweep("R9");
    wr(1'b1, 8'h78);
    sweep("R9");
    wr(1'b1, 8'h00);
    sweep("R9");
    wr(1'b1, 8'h10);
    sweep("R9");

    // R3: single-digit load takes one write only
    wr(1'b1, 8'hF2);
    wr(1'b0, 8'h09);
    wr(1'b0, 8'h84);
    wr(1'b1, 8'h58);
    sweep("R3");
    wr(1'b1, 8'h70);
    sweep("R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule